// File: doc/BRIEF.md
# CAN Receive Mailbox Bank

This block keeps a bank of receive mailboxes for frames that a CAN bit-level decoder has already assembled. Each mailbox stores one frame: the identifier with its standard/extended flag, the remote-request flag, the 4-bit data length code and eight data bytes. A frame offered on the input with a one-cycle strobe goes into the lowest-numbered mailbox that is currently free. That mailbox then reports ready in a per-mailbox status vector, and a single interrupt line stays high while any mailbox is ready.

A host reads one mailbox at a time by placing its index on a select input. Five combinational words come back: mode, identifier, status, data-low and data-high. Once the host has read mailboxes, it releases them by writing a bitmask re-arm command. When the parameter that enables it is set, the highest mailbox works in overwrite mode. If it is still full when a frame has nowhere else to go, the new frame replaces the old one and a lost-message flag sets. Without that mode, a frame that arrives when every mailbox is full is discarded.

Top module: `can_rxmb_bank`

## Requirements
- R1: After reset every mailbox is free. The ready vector is zero, irq is low, every ignored flag is clear and every stored field reads zero.
- R2: A frame strobed with frm_valid is stored in the lowest-numbered free mailbox. The bit of ready_vec whose index equals that mailbox number sets on the next clock edge. irq is high exactly while ready_vec is non-zero.
- R3: The identifier word of an extended frame holds 1 in bit 29 and the 29-bit ID in bits 28:0. For a standard frame, bit 29 is 0 and the 11-bit ID (frm_id[10:0]) sits in bits 28:18. All other bits read 0.
- R4: The status word holds the length code in bits 19:16, the remote-request flag in bit 20, ready in bit 23 and message-ignored in bit 24. All other bits read 0.
- R5: The data-low word returns bytes 0 to 3 and the data-high word returns bytes 4 to 7. Byte n of the frame is frm_data[8n+7:8n], and it appears in bits 8(n mod 4)+7 : 8(n mod 4) of its word.
- R6: The mode word carries the mailbox mode in bits 26:24. It reads 1 (receive) for ordinary mailboxes and 2 (receive with overwrite) for the last mailbox when OVWR_LAST is set. A select value at or above NUM_MB returns zero in all five read words.
- R7: A re-arm command (rearm_we high) clears the ready and ignored flags of every mailbox whose mask bit is set. Stored contents are kept, and the freed mailbox can be allocated again.
- R8: With OVWR_LAST set and all mailboxes full, a new frame replaces the contents of the last mailbox. Its ready flag stays set and its ignored flag sets. Ignored flags of the other mailboxes never set.
- R9: With OVWR_LAST clear and all mailboxes full, a new frame is dropped. No status bit and no stored field changes.
- R10: When a frame and a re-arm command arrive in the same cycle, allocation uses the mailbox state from before the command. The mailbox that receives the frame ignores its own mask bit.
- R11: While frm_valid is low, the frame inputs have no effect on any mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_id | input | 29 | Identifier (standard frames use bits 10:0) |
| frm_rtr | input | 1 | Remote-request frame |
| frm_len | input | 4 | Data length code |
| frm_data | input | 64 | Data bytes, byte n in bits 8n+7:8n |
| rearm_we | input | 1 | Re-arm command strobe |
| rearm_mask | input | NUM_MB | Mailboxes to release |
| rd_sel | input | SEL_W | Mailbox index for host reads |
| rd_mode_word | output | 32 | Mode word of the selected mailbox |
| rd_id_word | output | 32 | Identifier word of the selected mailbox |
| rd_status_word | output | 32 | Status word of the selected mailbox |
| rd_data_lo | output | 32 | Data bytes 0 to 3 |
| rd_data_hi | output | 32 | Data bytes 4 to 7 |
| ready_vec | output | NUM_MB | Ready flag per mailbox, bit index = mailbox number |
| irq | output | 1 | High while any mailbox is ready |

## Verification
The bench builds two copies with NUM_MB = 12. One has OVWR_LAST = 1 and the other OVWR_LAST = 0, and both see the same stimulus. This gives both the replace-and-flag path of the last mailbox and the silent drop of a frame with nowhere to go. Because SEL_W = 4, select values 12 to 15 exist, so the zero read-back for indices beyond the bank is exercised. Twelve mailboxes are few enough that random strobes and re-arm masks fill the bank, hit the overflow case and mix same-cycle frames and re-arms many times in a short run.

// File: rtl/can_rxmb_pkg.sv
`timescale 1ns/1ps
package can_rxmb_pkg;

    localparam int ID_W      = 29;
    localparam int STD_W     = 11;
    localparam int LEN_W     = 4;
    localparam int DATA_W    = 64;
    localparam int WORD_W    = 32;

    // word bit positions seen by the host
    localparam int ID_STD_LSB   = 18;
    localparam int ID_EXT_BIT   = 29;
    localparam int ST_LEN_LSB   = 16;
    localparam int ST_RTR_BIT   = 20;
    localparam int ST_READY_BIT = 23;
    localparam int ST_LOST_BIT  = 24;
    localparam int MODE_LSB     = 24;
    localparam int MODE_W       = 3;

    typedef enum logic [MODE_W-1:0] {
        MB_OFF      = 3'd0,
        MB_RX       = 3'd1,
        MB_RX_OVWR  = 3'd2,
        MB_CONSUMER = 3'd4,
        MB_PRODUCER = 3'd5
    } mb_mode_e;

    typedef struct packed {
        logic              ext;
        logic [ID_W-1:0]   id;
        logic              rtr;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [WORD_W-1:0] pack_id_word(frame_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        if (f.ext) begin
            w[ID_EXT_BIT] = 1'b1;
            w[ID_W-1:0]   = f.id;
        end else begin
            w[ID_STD_LSB +: STD_W] = f.id[STD_W-1:0];
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status_word(frame_t f, logic full, logic lost);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ST_LEN_LSB +: LEN_W] = f.len;
        w[ST_RTR_BIT]          = f.rtr;
        w[ST_READY_BIT]        = full;
        w[ST_LOST_BIT]         = lost;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_mode_word(mb_mode_e m);
        logic [WORD_W-1:0] w;
        w = '0;
        w[MODE_LSB +: MODE_W] = m;
        return w;
    endfunction

endpackage

// File: rtl/can_rxmb_alloc.sv
`timescale 1ns/1ps
// Picks the mailbox that takes an incoming frame: lowest free one,
// else the last one when it runs in overwrite mode, else none.
module can_rxmb_alloc #(
    parameter int NUM_MB    = 12,
    parameter bit OVWR_LAST = 1'b1
) (
    input  logic              valid,
    input  logic [NUM_MB-1:0] full_vec,
    output logic [NUM_MB-1:0] wr_vec
);

    logic found;

    always_comb begin
        wr_vec = '0;
        found  = 1'b0;
        for (int k = 0; k < NUM_MB; k++) begin
            if (!found && !full_vec[k]) begin
                wr_vec[k] = valid;
                found     = 1'b1;
            end
        end
        if (!found && OVWR_LAST) begin
            wr_vec[NUM_MB-1] = valid;
        end
    end

endmodule

// File: rtl/can_rxmb_slot.sv
`timescale 1ns/1ps
// One receive mailbox: stored frame plus ready and ignored flags.
module can_rxmb_slot
    import can_rxmb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  logic   rearm,
    input  frame_t wr_frame,
    output logic   full,
    output logic   lost,
    output frame_t frame
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full  <= 1'b0;
            lost  <= 1'b0;
            frame <= '0;
        end else if (wr_en) begin
            // a write wins over a re-arm bit in the same cycle
            frame <= wr_frame;
            full  <= 1'b1;
            if (full) begin
                lost <= 1'b1;
            end
        end else if (rearm) begin
            full <= 1'b0;
            lost <= 1'b0;
        end
    end

endmodule

// File: rtl/can_rxmb_bank.sv
`timescale 1ns/1ps
module can_rxmb_bank
    import can_rxmb_pkg::*;
#(
    parameter int NUM_MB    = 12,
    parameter bit OVWR_LAST = 1'b1,
    parameter int SEL_W     = $clog2(NUM_MB)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_valid,
    input  logic                frm_ext,
    input  logic [ID_W-1:0]     frm_id,
    input  logic                frm_rtr,
    input  logic [LEN_W-1:0]    frm_len,
    input  logic [DATA_W-1:0]   frm_data,
    input  logic                rearm_we,
    input  logic [NUM_MB-1:0]   rearm_mask,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [WORD_W-1:0]   rd_mode_word,
    output logic [WORD_W-1:0]   rd_id_word,
    output logic [WORD_W-1:0]   rd_status_word,
    output logic [WORD_W-1:0]   rd_data_lo,
    output logic [WORD_W-1:0]   rd_data_hi,
    output logic [NUM_MB-1:0]   ready_vec,
    output logic                irq
);

    localparam int LAST_MB = NUM_MB - 1;

    frame_t              in_frame;
    logic [NUM_MB-1:0]   wr_vec;
    logic [NUM_MB-1:0]   full_vec;
    logic [NUM_MB-1:0]   lost_vec;
    logic [NUM_MB-1:0]   rearm_vec;
    frame_t              slot_frame [NUM_MB];

    function automatic mb_mode_e mode_of(int k);
        return (OVWR_LAST && k == LAST_MB) ? MB_RX_OVWR : MB_RX;
    endfunction

    always_comb begin
        in_frame.ext  = frm_ext;
        in_frame.id   = frm_id;
        in_frame.rtr  = frm_rtr;
        in_frame.len  = frm_len;
        in_frame.data = frm_data;
    end

    assign rearm_vec = rearm_we ? rearm_mask : '0;

    can_rxmb_alloc #(
        .NUM_MB    (NUM_MB),
        .OVWR_LAST (OVWR_LAST)
    ) u_alloc (
        .valid    (frm_valid),
        .full_vec (full_vec),
        .wr_vec   (wr_vec)
    );

    for (genvar k = 0; k < NUM_MB; k++) begin : g_slot
        can_rxmb_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_vec[k]),
            .rearm    (rearm_vec[k]),
            .wr_frame (in_frame),
            .full     (full_vec[k]),
            .lost     (lost_vec[k]),
            .frame    (slot_frame[k])
        );
    end

    // host read mux; indices beyond the bank read as zero
    always_comb begin
        rd_mode_word   = '0;
        rd_id_word     = '0;
        rd_status_word = '0;
        rd_data_lo     = '0;
        rd_data_hi     = '0;
        for (int k = 0; k < NUM_MB; k++) begin
            if (rd_sel == SEL_W'(k)) begin
                rd_mode_word   = pack_mode_word(mode_of(k));
                rd_id_word     = pack_id_word(slot_frame[k]);
                rd_status_word = pack_status_word(slot_frame[k], full_vec[k], lost_vec[k]);
                rd_data_lo     = slot_frame[k].data[WORD_W-1:0];
                rd_data_hi     = slot_frame[k].data[DATA_W-1:WORD_W];
            end
        end
    end

    assign ready_vec = full_vec;
    assign irq       = |full_vec;

endmodule

// File: rtl/can_rxmb_chk.sv
`timescale 1ns/1ps
module can_rxmb_chk #(
    parameter int NUM_MB    = 12,
    parameter bit OVWR_LAST = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_valid,
    input logic              rearm_we,
    input logic [NUM_MB-1:0] rearm_mask,
    input logic [NUM_MB-1:0] ready_vec,
    input logic [NUM_MB-1:0] lost_vec
);

    AST_ONE_NEW_FRAME: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !rearm_we && !(&ready_vec)) |=>
        ($countones(ready_vec) == $countones($past(ready_vec)) + 1)); // R2

    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rearm_we && !frm_valid) |=> ((ready_vec & $past(rearm_mask)) == '0)); // R7

    AST_NO_FRAME_NO_READY: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> ((ready_vec & ~$past(ready_vec)) == '0)); // R11

    AST_LOST_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_vec[NUM_MB-1]) |-> ($past(frm_valid) && $past(ready_vec[NUM_MB-1]))); // R8

    AST_LOST_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
        lost_vec[NUM_MB-2:0] == '0); // R8

    if (!OVWR_LAST) begin : g_drop
        AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
            ((&ready_vec) && !rearm_we) |=> ((&ready_vec) && lost_vec == '0)); // R9
    end

endmodule

bind can_rxmb_bank can_rxmb_chk #(
    .NUM_MB    (NUM_MB),
    .OVWR_LAST (OVWR_LAST)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frm_valid  (frm_valid),
    .rearm_we   (rearm_we),
    .rearm_mask (rearm_mask),
    .ready_vec  (ready_vec),
    .lost_vec   (lost_vec)
);

// File: tb/test_can_rxmb_bank.sv
`timescale 1ns/1ps
module test_can_rxmb_bank;

    localparam int N = 12;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frm_valid = 1'b0;
    logic          frm_ext = 1'b0;
    logic [28:0]   frm_id = '0;
    logic          frm_rtr = 1'b0;
    logic [3:0]    frm_len = '0;
    logic [63:0]   frm_data = '0;
    logic          rearm_we = 1'b0;
    logic [N-1:0]  rearm_mask = '0;
    logic [SW-1:0] rd_sel = '0;

    logic [31:0]  a_mode, a_id, a_st, a_lo, a_hi, b_mode, b_id, b_st, b_lo, b_hi;
    logic [N-1:0] a_rdy, b_rdy;
    logic         a_irq, b_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    can_rxmb_bank #(.NUM_MB(N), .OVWR_LAST(1'b1), .SEL_W(SW)) i_can_rxmb_bank (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_id(frm_id),
        .frm_rtr(frm_rtr), .frm_len(frm_len), .frm_data(frm_data), .rearm_we(rearm_we),
        .rearm_mask(rearm_mask), .rd_sel(rd_sel), .rd_mode_word(a_mode), .rd_id_word(a_id),
        .rd_status_word(a_st), .rd_data_lo(a_lo), .rd_data_hi(a_hi), .ready_vec(a_rdy), .irq(a_irq));

    can_rxmb_bank #(.NUM_MB(N), .OVWR_LAST(1'b0), .SEL_W(SW)) i_can_rxmb_bank_drop (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_id(frm_id),
        .frm_rtr(frm_rtr), .frm_len(frm_len), .frm_data(frm_data), .rearm_we(rearm_we),
        .rearm_mask(rearm_mask), .rd_sel(rd_sel), .rd_mode_word(b_mode), .rd_id_word(b_id),
        .rd_status_word(b_st), .rd_data_lo(b_lo), .rd_data_hi(b_hi), .ready_vec(b_rdy), .irq(b_irq));

    // reference model, index 0 = overwrite copy, 1 = drop copy
    bit        m_full [2][N];
    bit        m_lost [2][N];
    bit        m_ext  [2][N];
    bit [28:0] m_id   [2][N];
    bit        m_rtr  [2][N];
    bit [3:0]  m_len  [2][N];
    bit [63:0] m_dat  [2][N];

    function automatic logic [31:0] exp_id(bit e, bit [28:0] id);
        return e ? {3'b001, id} : {3'b000, id[10:0], 18'd0};
    endfunction

    function automatic logic [31:0] exp_status(bit f, bit l, bit r, bit [3:0] ln);
        logic [31:0] w = '0;
        w[24] = l; w[23] = f; w[20] = r; w[19:16] = ln;
        return w;
    endfunction

    function automatic logic [31:0] exp_mode(int o, int k);
        logic [31:0] w = '0;
        if (k < N) w[26:24] = (o == 0 && k == N-1) ? 3'd2 : 3'd1;
        return w;
    endfunction

    function automatic logic [N-1:0] exp_ready(int o);
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = m_full[o][k];
        return v;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(bit e, bit [28:0] id, bit r, bit [3:0] ln, bit [63:0] d,
                              bit rw, bit [N-1:0] mask);
        for (int o = 0; o < 2; o++) begin
            int sel = -1;
            for (int k = N-1; k >= 0; k--) if (!m_full[o][k]) sel = k;
            if (sel < 0 && o == 0) sel = N-1;
            for (int k = 0; k < N; k++) begin
                if (k == sel) begin
                    if (m_full[o][k]) m_lost[o][k] = 1'b1;
                    m_full[o][k] = 1'b1;
                    m_ext[o][k] = e; m_id[o][k] = id; m_rtr[o][k] = r;
                    m_len[o][k] = ln; m_dat[o][k] = d;
                end else if (rw && mask[k]) begin
                    m_full[o][k] = 1'b0;
                    m_lost[o][k] = 1'b0;
                end
            end
        end
    endtask

    task automatic model_rearm(bit [N-1:0] mask);
        for (int o = 0; o < 2; o++)
            for (int k = 0; k < N; k++)
                if (mask[k]) begin m_full[o][k] = 1'b0; m_lost[o][k] = 1'b0; end
    endtask

    // one bus cycle; the model follows whatever the block should do
    task automatic step(bit v, bit e, bit [28:0] id, bit r, bit [3:0] ln, bit [63:0] d,
                        bit rw, bit [N-1:0] mask);
        @(negedge clk);
        frm_valid = v; frm_ext = e; frm_id = id; frm_rtr = r; frm_len = ln; frm_data = d;
        rearm_we = rw; rearm_mask = mask;
        if (v) model_step(e, id, r, ln, d, rw, mask);
        else if (rw) model_rearm(mask);
        @(negedge clk);
        frm_valid = 1'b0; rearm_we = 1'b0;
        frm_id = ~frm_id; frm_data = ~frm_data; // R11: idle wiggle
    endtask

    task automatic rand_frame(bit v, bit rw, bit [N-1:0] mask);
        bit [63:0] d = {$urandom, $urandom};
        step(v, 1'($urandom), 29'($urandom), 1'($urandom), 4'($urandom), d, rw, mask);
    endtask

    task automatic check_all(string tag);
        chk(tag, 64'(a_rdy), 64'(exp_ready(0)));
        chk(tag, 64'(b_rdy), 64'(exp_ready(1)));
        chk("R2", 64'(a_irq), 64'(|exp_ready(0)));
        chk("R2", 64'(b_irq), 64'(|exp_ready(1)));
        for (int k = 0; k < 16; k++) begin
            rd_sel = SW'(k);
            #1;
            if (k < N) begin
                chk("R6", 64'(a_mode), 64'(exp_mode(0, k)));
                chk("R6", 64'(b_mode), 64'(exp_mode(1, k)));
                chk("R3", 64'(a_id), 64'(exp_id(m_ext[0][k], m_id[0][k])));
                chk("R3", 64'(b_id), 64'(exp_id(m_ext[1][k], m_id[1][k])));
                chk("R4", 64'(a_st), 64'(exp_status(m_full[0][k], m_lost[0][k], m_rtr[0][k], m_len[0][k])));
                chk("R4", 64'(b_st), 64'(exp_status(m_full[1][k], m_lost[1][k], m_rtr[1][k], m_len[1][k])));
                chk("R5", {a_hi, a_lo}, m_dat[0][k]);
                chk("R5", {b_hi, b_lo}, m_dat[1][k]);
            end else begin
                chk("R6", {a_mode, a_id}, 64'd0);
                chk("R6", {a_st, a_lo ^ a_hi}, 64'd0);
                chk("R6", {b_mode, b_id}, 64'd0);
                chk("R6", {b_st, b_lo ^ b_hi}, 64'd0);
            end
        end
    endtask

    initial begin : watchdog
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R3/R5 directed: standard and extended identifiers, distinct bytes
        step(1, 0, 29'h1fff_f7a5, 1, 4'd8, 64'h0807_0605_0403_0201, 0, '0);
        check_all("R2");
        step(1, 1, 29'h1234_5678, 0, 4'd3, 64'hf0e0_d0c0_b0a0_9080, 0, '0);
        check_all("R3");

        // fill the remaining mailboxes, then overflow
        for (int i = 2; i < N; i++) rand_frame(1, 0, '0);
        check_all("R2");
        step(1, 1, 29'h0abc_def0, 1, 4'd5, 64'h1122_3344_5566_7788, 0, '0);
        check_all("R8");
        rd_sel = SW'(N-1); #1;
        chk("R8", 64'(a_st[24]), 64'd1);
        chk("R9", 64'(b_st[24]), 64'd0);
        chk("R8", {a_hi, a_lo}, 64'h1122_3344_5566_7788);

        // R7: release one in the middle, next frame reuses it
        step(0, 0, '0, 0, '0, '0, 1, 12'h020);
        check_all("R7");
        rand_frame(1, 0, '0);
        check_all("R7");
        chk("R7", 64'(a_rdy[5]), 64'd1);

        // R10: frame and re-arm in the same cycle
        step(0, 0, '0, 0, '0, '0, 1, '1);
        for (int i = 0; i < 3; i++) rand_frame(1, 0, '0);
        rand_frame(1, 1, 12'h009);
        check_all("R10");
        chk("R10", 64'(a_rdy), 64'h00e);
        rand_frame(1, 0, '0);
        check_all("R10");
        chk("R10", 64'(a_rdy), 64'h00f);

        // R11: idle cycles with changing frame inputs
        step(0, 1, 29'h1555_5555, 1, 4'hf, '1, 0, '1);
        check_all("R11");

        // random mix
        for (int i = 0; i < 300; i++) begin
            bit v = ($urandom % 10) < 7;
            bit rw = ($urandom % 10) < 3;
            rand_frame(v, rw, N'($urandom));
            check_all(v ? "R2" : "R11");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule